// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one configurable logic cell of the kind found at the output of a small programmable logic device. It receives a sum-of-products term from an upstream product-term array. A single storage element takes that term and works as a bypass, a D flip-flop, a T flip-flop or a transparent latch. The result drives a pin value and a pin enable toward an I/O cell. The same result, before any inversion, goes back to the interconnect as feedback.

Configuration is a set of static inputs. The block copies them into a shadow register while reset is asserted and ignores them at all other times. The configuration selects the storage mode, the toggle behaviour, the output inversion and which of two clocks drives the cell. A buried build (parameter `BURIED`) adds a second element that captures the pin input combinatorially, in a register or in a latch, so that asynchronous pin signals can be synchronised before they enter the logic.

Top module: `pld_macrocell`

## Requirements
- R1: With output mode 0 (or the unused code 3), `fb_out` equals `sum_in` at the same time, with no clock involved.
- R2: `pin_out` is `fb_out` inverted when the inversion bit is 1, and equal to `fb_out` when it is 0.
- R3: With output mode 1 and the toggle bit 0, `fb_out` takes the value `sum_in` had at the last rising edge of the selected clock.
- R4: With output mode 1 and the toggle bit 1, a high `sum_in` at a rising edge of the selected clock inverts the stored bit, and a low `sum_in` keeps it.
- R5: With output mode 2, `fb_out` follows `sum_in` while the selected clock is high and holds the value present at the falling edge while that clock is low.
- R6: The clock-select bit 0 chooses `clk_a` and 1 chooses `clk_b` for every storage element in the cell.
- R7: `fb_out` always carries the value before inversion: the stored bit in modes 1 and 2, and `sum_in` in mode 0.
- R8: A synchronous active-high `rst` clears the storage to 0 in every mode, so after reset `pin_out` reads back the inversion bit.
- R9: The configuration inputs are copied on rising edges of `clk_a` while `rst` is high. Changes to them while `rst` is low have no effect on any output.
- R10: In the buried build, `cap_out` gives `pin_in` directly for capture mode 0, the value at the last rising edge of the selected clock for capture mode 1, and a transparent-high latch of `pin_in` for capture mode 2.
- R11: `pin_oe` follows `oe_in` at the same time, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock choice |
| clk_b | input | 1 | Second clock choice |
| rst | input | 1 | Synchronous active-high reset; also opens the configuration shadow |
| sum_in | input | 1 | Sum term from the product-term array |
| pin_in | input | 1 | Value seen at the pin, used by the capture path |
| oe_in | input | 1 | Output-enable term |
| cfg_omode | input | 2 | Output mode: 0 bypass, 1 register, 2 latch, 3 bypass |
| cfg_toggle | input | 1 | Register acts as T-type when 1 |
| cfg_invert | input | 1 | Inverts the pin value when 1 |
| cfg_clksel | input | 1 | 0 picks clk_a, 1 picks clk_b |
| cfg_cmode | input | 2 | Capture mode: 0 direct, 1 register, 2 latch, 3 direct |
| pin_out | output | 1 | Value toward the I/O cell |
| pin_oe | output | 1 | Enable toward the I/O cell |
| fb_out | output | 1 | Non-inverted feedback to the interconnect |
| cap_out | output | 1 | Captured pin value (0 when not buried) |

## Verification
The bypass results, the inversion and the enable follow their inputs at the same time. The register results change at the rising edge of the selected clock. The latch results follow their input during the high phase and hold from the falling edge. The bench changes `sum_in` and `pin_in` 1 ns after a falling edge of the clock it expects the cell to use. It checks the held state at that point, and checks again 1 ns after the next rising edge, where a register has loaded and a latch is transparent. Because all stimulus edges are odd nanosecond offsets and both clock periods are even, no sample falls on any clock edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    OM_BYPASS = 2'd0,
    OM_REG    = 2'd1,
    OM_LATCH  = 2'd2,
    OM_SPARE  = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    CM_DIRECT = 2'd0,
    CM_REG    = 2'd1,
    CM_LATCH  = 2'd2,
    CM_SPARE  = 2'd3
  } cap_mode_e;

  typedef struct packed {
    logic [1:0] omode;
    logic       toggle;
    logic       invert;
    logic       clksel;
    logic [1:0] cmode;
  } mcell_cfg_t;

  localparam int CFG_W = $bits(mcell_cfg_t);

  // next value of the register: load in D use, conditional flip in T use
  function automatic logic next_state(input logic q, input logic d, input logic tog);
    return tog ? (q ^ d) : d;
  endfunction

  // polarity stage placed after storage
  function automatic logic apply_pol(input logic v, input logic inv);
    return inv ? ~v : v;
  endfunction

endpackage

// File: rtl/mcell_cfg_shadow.sv
module mcell_cfg_shadow #(
  parameter int W = mcell_pkg::CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cfg_in,
  output logic [W-1:0] cfg_q
);
  // configuration is only open while reset is held
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/mcell_store.sv
module mcell_store (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic use_ff,
  input  logic use_latch,
  input  logic tog,
  output logic q_ff,
  output logic q_out
);
  import mcell_pkg::*;

  logic held;

  always_ff @(posedge clk) begin
    if (rst) q_ff <= 1'b0;
    else     q_ff <= next_state(q_ff, d, tog);
  end

  // latch model: value frozen at the closing (falling) edge
  always_ff @(negedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= d;
  end

  always_comb begin
    if (use_ff)         q_out = q_ff;
    else if (use_latch) q_out = (clk && !rst) ? d : held;
    else                q_out = d;
  end
endmodule

// File: rtl/mcell_outpath.sv
module mcell_outpath (
  input  logic stored,
  input  logic invert,
  input  logic oe_in,
  output logic pin_out,
  output logic pin_oe
);
  import mcell_pkg::*;
  assign pin_out = apply_pol(stored, invert);
  assign pin_oe  = oe_in;
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter bit BURIED = 1'b1
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       rst,
  input  logic       sum_in,
  input  logic       pin_in,
  input  logic       oe_in,
  input  logic [1:0] cfg_omode,
  input  logic       cfg_toggle,
  input  logic       cfg_invert,
  input  logic       cfg_clksel,
  input  logic [1:0] cfg_cmode,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out,
  output logic       cap_out
);
  import mcell_pkg::*;

  mcell_cfg_t cfg_in_s, cfg_q;
  logic [CFG_W-1:0] cfg_q_vec;

  // named internal events, exposed for the checker
  logic clk_sel;
  logic mode_reg, mode_latch, mode_tog, cfg_inv_q;
  logic cap_reg, cap_latch;
  logic ff_q, stored;
  logic cap_ff;

  assign cfg_in_s = '{omode: cfg_omode, toggle: cfg_toggle, invert: cfg_invert,
                      clksel: cfg_clksel, cmode: cfg_cmode};

  mcell_cfg_shadow #(.W(CFG_W)) u_cfg (
    .clk    (clk_a),
    .rst    (rst),
    .cfg_in (cfg_in_s),
    .cfg_q  (cfg_q_vec)
  );
  assign cfg_q = mcell_cfg_t'(cfg_q_vec);

  assign clk_sel    = cfg_q.clksel ? clk_b : clk_a;
  assign mode_reg   = (cfg_q.omode == OM_REG);
  assign mode_latch = (cfg_q.omode == OM_LATCH);
  assign mode_tog   = cfg_q.toggle;
  assign cfg_inv_q  = cfg_q.invert;
  assign cap_reg    = (cfg_q.cmode == CM_REG);
  assign cap_latch  = (cfg_q.cmode == CM_LATCH);

  mcell_store u_main (
    .clk       (clk_sel),
    .rst       (rst),
    .d         (sum_in),
    .use_ff    (mode_reg),
    .use_latch (mode_latch),
    .tog       (mode_tog),
    .q_ff      (ff_q),
    .q_out     (stored)
  );

  assign fb_out = stored;

  mcell_outpath u_out (
    .stored  (stored),
    .invert  (cfg_inv_q),
    .oe_in   (oe_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  generate
    if (BURIED) begin : g_capture
      mcell_store u_cap (
        .clk       (clk_sel),
        .rst       (rst),
        .d         (pin_in),
        .use_ff    (cap_reg),
        .use_latch (cap_latch),
        .tog       (1'b0),
        .q_ff      (cap_ff),
        .q_out     (cap_out)
      );
    end else begin : g_no_capture
      assign cap_ff  = 1'b0;
      assign cap_out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mcell_checker.sv
module mcell_checker (
  input logic       clk_a,
  input logic       clk_sel,
  input logic       rst,
  input logic       sum_in,
  input logic       pin_in,
  input logic       mode_reg,
  input logic       mode_tog,
  input logic       cap_reg,
  input logic       cfg_inv_q,
  input logic       ff_q,
  input logic       cap_ff,
  input logic       pin_out,
  input logic       fb_out,
  input logic [6:0] cfg_q_vec
);
  AST_POLARITY: assert property (@(posedge clk_a) disable iff (rst)
    pin_out == (fb_out ^ cfg_inv_q)); // R2

  AST_DREG_LOAD: assert property (@(posedge clk_sel) disable iff (rst)
    (mode_reg && !mode_tog) |=> (ff_q == $past(sum_in))); // R3

  AST_TREG_FLIP: assert property (@(posedge clk_sel) disable iff (rst)
    (mode_reg && mode_tog) |=> (ff_q == ($past(ff_q) ^ $past(sum_in)))); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk_sel)
    rst |=> (ff_q == 1'b0)); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk_a) disable iff (rst)
    1'b1 |=> $stable(cfg_q_vec)); // R9

  AST_CAP_LOAD: assert property (@(posedge clk_sel) disable iff (rst)
    cap_reg |=> (cap_ff == $past(pin_in))); // R10
endmodule

bind pld_macrocell mcell_checker u_chk (
  .clk_a     (clk_a),
  .clk_sel   (clk_sel),
  .rst       (rst),
  .sum_in    (sum_in),
  .pin_in    (pin_in),
  .mode_reg  (mode_reg),
  .mode_tog  (mode_tog),
  .cap_reg   (cap_reg),
  .cfg_inv_q (cfg_inv_q),
  .ff_q      (ff_q),
  .cap_ff    (cap_ff),
  .pin_out   (pin_out),
  .fb_out    (fb_out),
  .cfg_q_vec (cfg_q_vec)
);

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst = 1'b1;
  logic sum_in = 1'b0, pin_in = 1'b0, oe_in = 1'b0;
  logic [1:0] cfg_omode = 2'd0, cfg_cmode = 2'd0;
  logic cfg_toggle = 1'b0, cfg_invert = 1'b0, cfg_clksel = 1'b0;
  logic pin_out, pin_oe, fb_out, cap_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk_a = ~clk_a;   // 125 MHz
  always #6 clk_b = ~clk_b;

  pld_macrocell dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .sum_in(sum_in), .pin_in(pin_in),
    .oe_in(oe_in), .cfg_omode(cfg_omode), .cfg_toggle(cfg_toggle),
    .cfg_invert(cfg_invert), .cfg_clksel(cfg_clksel), .cfg_cmode(cfg_cmode),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .cap_out(cap_out)
  );

  // configuration the bench believes the cell holds
  logic [1:0] m_om, m_cm;
  logic m_tog, m_inv, m_cs;
  logic exp_q, exp_c;

  task automatic chk(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b om=%0d tog=%0b inv=%0b cs=%0b cm=%0d t=%0t",
               tag, act, expv, m_om, m_tog, m_inv, m_cs, m_cm, $time);
    end
  endtask

  task automatic wait_sel(input bit rising);
    if (m_cs) begin
      if (rising) @(posedge clk_b); else @(negedge clk_b);
    end else begin
      if (rising) @(posedge clk_a); else @(negedge clk_a);
    end
    #1;
  endtask

  function automatic string mtag(input logic [1:0] om, input logic tog);
    if (om == 2'd1) return tog ? "R4 R6 R9" : "R3 R6 R9";
    if (om == 2'd2) return "R5 R6 R9";
    return "R1 R9";
  endfunction

  function automatic string ctag(input logic [1:0] cm);
    return (cm == 2'd1 || cm == 2'd2) ? "R10 R6" : "R10";
  endfunction

  // all outputs against the model; bypass modes use the live inputs
  task automatic check_all(input logic v, input logic p, input string phase);
    logic fbx, cpx;
    fbx = (m_om == 2'd1 || m_om == 2'd2) ? exp_q : v;
    cpx = (m_cm == 2'd1 || m_cm == 2'd2) ? exp_c : p;
    chk({mtag(m_om, m_tog), " R7 fb ", phase}, fb_out, fbx);
    chk({"R2 pin ", phase}, pin_out, m_inv ? ~fbx : fbx);
    chk({ctag(m_cm), " cap ", phase}, cap_out, cpx);
    chk("R11 oe", pin_oe, oe_in);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] pat;
    for (int cfg = 0; cfg < 48; cfg++) begin
      m_om  = 2'((cfg >> 2) % 4);
      m_tog = cfg[0];
      m_inv = cfg[1];
      m_cs  = cfg[4];
      m_cm  = 2'(cfg % 3);
      // reset with the wanted configuration on the inputs
      rst = 1'b1; sum_in = 1'b0; pin_in = 1'b0;
      cfg_omode = m_om; cfg_toggle = m_tog; cfg_invert = m_inv;
      cfg_clksel = m_cs; cfg_cmode = m_cm;
      repeat (5) @(posedge clk_b);
      wait_sel(1'b0);
      rst = 1'b0;
      exp_q = 1'b0; exp_c = 1'b0;
      // scramble configuration inputs: must have no effect now
      cfg_omode = ~m_om; cfg_toggle = ~m_tog; cfg_invert = ~m_inv;
      cfg_clksel = ~m_cs; cfg_cmode = ~m_cm;
      chk("R8 fb after reset", fb_out, 1'b0);
      chk("R8 pin after reset", pin_out, m_inv);
      pat = 16'hB4D3 ^ 16'(cfg * 16'h2F1);
      for (int k = 0; k < 10; k++) begin
        logic v, p;
        v = pat[k];
        p = pat[15 - k];
        wait_sel(1'b0);
        sum_in = v; pin_in = p; oe_in = pat[(k + 3) % 16];
        #0;
        check_all(v, p, "low");
        wait_sel(1'b1);
        if (m_om == 2'd1)      exp_q = m_tog ? (v ? ~exp_q : exp_q) : v;
        else if (m_om == 2'd2) exp_q = v;
        if (m_cm != 2'd0)      exp_c = p;
        check_all(v, p, "high");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule